// File: doc/BRIEF.md
# Sine-Modulated PWM Reference Generator

This block turns a digital sine reference into a pulse train whose duty cycle follows a sine shape, for driving a single-phase bridge inverter. A carrier counter climbs from zero to its ceiling and then falls back to zero, producing a symmetric triangle at the switching rate. At each turning point of the carrier, a threshold is taken from a computed sine table scaled by a runtime modulation depth. The main output is high while the carrier lies below that threshold.

A separate prescaler divides the system clock into sample ticks. Each tick moves the table position one step through a 100-sample output period, so the programmed divider sets the output frequency. A second output carries the plain logical complement, with no delay inserted. Dead-time shaping is done downstream. The current table position and the threshold in force are also brought out, so that the surrounding logic can observe the phase and the level.

Top module: `spwm_gen`

## Requirements
- R1: The carrier visits 0,1,...,1023 and then 1022,...,1, repeating with a period of 2046 clocks, so rising edges of `pwm_p` under a steady threshold are 2046 clocks apart.
- R2: With `step_div` = D, `phase_idx` advances by one after every D+1 clocks counted from reset release. It counts 0 to 99 and then returns to 0.
- R3: Let S(i) = round(512·sin(2πi/100)), and let m = `mod_idx`/256. The threshold is then 512 + trunc(|S(i)|·`mod_idx`/256) when S(i) ≥ 0, and 512 − trunc(|S(i)|·`mod_idx`/256) otherwise. The truncated deviation always rounds toward mid-scale.
- R4: `duty_lvl` takes a new value only in the clock that follows a carrier value of 0 or 1023. Changing `mod_idx` in mid-slope leaves `duty_lvl` unchanged until the next turning point.
- R5: Under a steady threshold c (1 ≤ c ≤ 1023), `pwm_p` is high for 2c−1 clocks out of each 2046-clock carrier period.
- R6: Outside reset, `pwm_n` is the inverse of `pwm_p`, so it is high for 2046−(2c−1) clocks per carrier period.
- R7: While synchronous reset `rst` is high, `phase_idx` and `duty_lvl` read 0 and both `pwm_p` and `pwm_n` are low.
- R8: `mod_idx` = 0 gives a threshold of 512 at every table position, for 50% duty on both outputs.
- R9: `mod_idx` = 255 gives the extreme thresholds 1022 at position 25 and 2 at position 75.
- R10: If `step_div` is lowered below the prescaler's current count, a tick occurs on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_idx | input | 8 | Modulation depth, unsigned 0.8 fixed point |
| step_div | input | 16 | Clocks per sample tick, minus one |
| pwm_p | output | 1 | Sine-modulated PWM output |
| pwm_n | output | 1 | Logical complement of `pwm_p` (low in reset) |
| phase_idx | output | 7 | Current sine table position, 0..99 |
| duty_lvl | output | 10 | Threshold currently compared against the carrier |

## Verification
The embedded properties assume that `rst` is held for at least one clock before any check applies. They also assume that `mod_idx` and `step_div` change only between clock edges. The bench drives both inputs on falling edges, so that every value is settled at the rising edge. It lowers `step_div` only from its largest value, which is the case R10 describes. Threshold and duty checks are taken after at least one full carrier period in which the table position and `mod_idx` stay constant, so the latch has caught up with the inputs.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

   // direction of the triangle carrier
   typedef enum logic {
      SLOPE_UP = 1'b0,
      SLOPE_DN = 1'b1
   } slope_e;

   localparam real SPWM_TWO_PI = 6.283185307179586;

endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier
   import spwm_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] cnt,
   output logic             turn
);

   localparam logic [CNT_W-1:0] TOP  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   slope_e            slope_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= ZERO;
         slope_q <= SLOPE_UP;
      end else begin
         unique case (slope_q)
            SLOPE_UP: begin
               if (cnt_q == TOP) begin
                  cnt_q   <= TOP - ONE;
                  slope_q <= SLOPE_DN;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            SLOPE_DN: begin
               if (cnt_q == ONE) begin
                  cnt_q   <= ZERO;
                  slope_q <= SLOPE_UP;
               end else begin
                  cnt_q <= cnt_q - ONE;
               end
            end
            default: begin
               cnt_q   <= ZERO;
               slope_q <= SLOPE_UP;
            end
         endcase
      end
   end

   assign cnt  = cnt_q;
   assign turn = (cnt_q == ZERO) || (cnt_q == TOP);

   // R1: the carrier reverses at its ceiling
   p_turn_top_r1 : assert property (@(posedge clk) disable iff (rst)
      (cnt_q == TOP) |=> (cnt_q == TOP - ONE));

   // R1: the carrier reverses at zero
   p_turn_bot_r1 : assert property (@(posedge clk) disable iff (rst)
      (cnt_q == ZERO) |=> (cnt_q == ONE));

   // R1: the carrier never holds still
   p_moves_r1 : assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/spwm_pacer.sv
module spwm_pacer #(
   parameter int SAMPLES = 100,
   parameter int PRESC_W = 16,
   localparam int IDX_W  = $clog2(SAMPLES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [PRESC_W-1:0] step_div,
   output logic [IDX_W-1:0]   idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(SAMPLES - 1);

   logic [PRESC_W-1:0] pc_q;
   logic [IDX_W-1:0]   idx_q;
   logic               tick;

   // a tick fires as soon as the count has reached or passed the divider
   assign tick = (pc_q >= step_div);

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         idx_q <= '0;
      end else begin
         if (tick) begin
            pc_q <= '0;
            if (idx_q == LAST) idx_q <= '0;
            else               idx_q <= idx_q + IDX_W'(1);
         end else begin
            pc_q <= pc_q + PRESC_W'(1);
         end
      end
   end

   assign idx = idx_q;

   // R2: the position stays inside the table
   p_idx_range_r2 : assert property (@(posedge clk) disable iff (rst)
      idx_q <= LAST);

   // R2: a tick moves the position forward by one
   p_idx_step_r2 : assert property (@(posedge clk) disable iff (rst)
      (tick && idx_q != LAST) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

   // R2: the position wraps after the last sample
   p_idx_wrap_r2 : assert property (@(posedge clk) disable iff (rst)
      (tick && idx_q == LAST) |=> (idx_q == '0));

   // R2: without a tick the position holds
   p_idx_hold_r2 : assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(idx_q));

endmodule

// File: rtl/spwm_wave_rom.sv
module spwm_wave_rom
   import spwm_pkg::*;
#(
   parameter int SAMPLES = 100,
   parameter int CNT_W   = 10,
   parameter int MI_W    = 8,
   localparam int IDX_W  = $clog2(SAMPLES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [IDX_W-1:0] idx,
   input  logic [MI_W-1:0]  mod_idx,
   output logic [CNT_W-1:0] lvl
);

   localparam int               HALF_I = 2 ** (CNT_W - 1);
   localparam logic [CNT_W-1:0] HALF   = CNT_W'(HALF_I);
   localparam int               PW     = CNT_W + MI_W;

   logic [CNT_W-1:0]   mag_tab [SAMPLES];
   logic [SAMPLES-1:0] neg_tab;

   // table of rounded sine magnitudes with a separate sign bit
   for (genvar g = 0; g < SAMPLES; g++) begin : g_tab
      localparam real ANG  = SPWM_TWO_PI * real'(g) / real'(SAMPLES);
      localparam real RAW  = real'(HALF_I) * $sin(ANG);
      localparam int  SVAL = int'(RAW);
      localparam int  AMAG = (SVAL < 0) ? -SVAL : SVAL;
      assign mag_tab[g] = AMAG[CNT_W-1:0];
      assign neg_tab[g] = (SVAL < 0);
   end

   logic [CNT_W-1:0] mag_sel;
   logic             neg_sel;
   logic [PW-1:0]    prod;
   logic [CNT_W-1:0] dev;

   assign mag_sel = mag_tab[idx];
   assign neg_sel = neg_tab[idx];

   // single multiplier; dropping the fraction pulls the deviation toward mid-scale
   assign prod = {{MI_W{1'b0}}, mag_sel} * {{CNT_W{1'b0}}, mod_idx};
   assign dev  = prod[PW-1:MI_W];
   assign lvl  = neg_sel ? (HALF - dev) : (HALF + dev);

   // R3: the scaled level never touches either rail of the carrier
   p_lvl_span_r3 : assert property (@(posedge clk) disable iff (rst)
      (lvl != '0) && (lvl != {CNT_W{1'b1}}));

   // R8: zero depth sits at mid-scale
   p_zero_depth_r8 : assert property (@(posedge clk) disable iff (rst)
      (mod_idx == '0) |-> (lvl == HALF));

   // R3: position zero has no sine deviation
   p_origin_mid_r3 : assert property (@(posedge clk) disable iff (rst)
      (idx == '0) |-> (lvl == HALF));

endmodule

// File: rtl/spwm_gen.sv
module spwm_gen #(
   parameter int CNT_W   = 10,
   parameter int SAMPLES = 100,
   parameter int MI_W    = 8,
   parameter int PRESC_W = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [MI_W-1:0]            mod_idx,
   input  logic [PRESC_W-1:0]         step_div,
   output logic                       pwm_p,
   output logic                       pwm_n,
   output logic [$clog2(SAMPLES)-1:0] phase_idx,
   output logic [CNT_W-1:0]           duty_lvl
);

   localparam int IDX_W = $clog2(SAMPLES);

   // elaboration-time parameter checks
   if (CNT_W < 4 || CNT_W > 16) begin : g_bad_cnt
      $error("spwm_gen: CNT_W out of range");
   end
   if (SAMPLES < 4 || SAMPLES > 1024) begin : g_bad_samp
      $error("spwm_gen: SAMPLES out of range");
   end
   if (MI_W < 1 || MI_W > 12) begin : g_bad_mi
      $error("spwm_gen: MI_W out of range");
   end
   if (PRESC_W < 1 || PRESC_W > 32) begin : g_bad_presc
      $error("spwm_gen: PRESC_W out of range");
   end

   logic [CNT_W-1:0] cnt;
   logic             turn;
   logic [IDX_W-1:0] idx;
   logic [CNT_W-1:0] lvl_next;
   logic [CNT_W-1:0] cmp_q;
   logic             below;

   spwm_carrier #(
      .CNT_W (CNT_W)
   ) u_carrier (
      .clk  (clk),
      .rst  (rst),
      .cnt  (cnt),
      .turn (turn)
   );

   spwm_pacer #(
      .SAMPLES (SAMPLES),
      .PRESC_W (PRESC_W)
   ) u_pacer (
      .clk      (clk),
      .rst      (rst),
      .step_div (step_div),
      .idx      (idx)
   );

   spwm_wave_rom #(
      .SAMPLES (SAMPLES),
      .CNT_W   (CNT_W),
      .MI_W    (MI_W)
   ) u_rom (
      .clk     (clk),
      .rst     (rst),
      .idx     (idx),
      .mod_idx (mod_idx),
      .lvl     (lvl_next)
   );

   // threshold is only taken at the carrier's turning points
   always_ff @(posedge clk) begin
      if (rst)       cmp_q <= '0;
      else if (turn) cmp_q <= lvl_next;
   end

   assign below = (cnt < cmp_q);

   if (REG_OUT) begin : g_reg_out
      logic pp_q, pn_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            pp_q <= 1'b0;
            pn_q <= 1'b0;
         end else begin
            pp_q <= below;
            pn_q <= ~below;
         end
      end
      assign pwm_p = pp_q;
      assign pwm_n = pn_q;

      // R5: the output follows the carrier-versus-threshold result one clock later
      p_out_lvl_r5 : assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> (pwm_p == ($past(cnt) < $past(cmp_q))));
   end else begin : g_comb_out
      assign pwm_p = ~rst & below;
      assign pwm_n = ~rst & ~below;
   end

   assign phase_idx = idx;
   assign duty_lvl  = cmp_q;

   // R4: the threshold holds between turning points
   p_hold_lvl_r4 : assert property (@(posedge clk) disable iff (rst)
      !turn |=> $stable(cmp_q));

   // R6: the two outputs are inverse once out of reset
   p_out_comp_r6 : assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (pwm_n == !pwm_p));

   // R7: at most one output is high at any time
   p_no_overlap_r7 : assert property (@(posedge clk) disable iff (rst)
      !(pwm_p && pwm_n));

endmodule

// File: tb/sim_spwm_gen.sv
`timescale 1ns/1ps
module sim_spwm_gen;

   localparam int PERIOD = 2046;
   localparam int NVEC   = 8;
   // each entry: {table position, modulation depth}
   localparam logic [15:0] VEC [NVEC] = '{
      {8'd0,  8'd200},
      {8'd25, 8'd255},
      {8'd75, 8'd255},
      {8'd10, 8'd128},
      {8'd50, 8'd200},
      {8'd60, 8'd0},
      {8'd90, 8'd64},
      {8'd33, 8'd180}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  mod_idx = '0;
   logic [15:0] step_div = '0;
   logic        pwm_p, pwm_n;
   logic [6:0]  phase_idx;
   logic [9:0]  duty_lvl;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   spwm_gen u0 (
      .clk       (clk),
      .rst       (rst),
      .mod_idx   (mod_idx),
      .step_div  (step_div),
      .pwm_p     (pwm_p),
      .pwm_n     (pwm_n),
      .phase_idx (phase_idx),
      .duty_lvl  (duty_lvl)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected threshold straight from the R3 formula
   function automatic int exp_lvl(input int k, input int m);
      real s;
      int  mag, dev;
      s   = 512.0 * $sin(6.283185307179586 * real'(k) / 100.0);
      mag = (s < 0.0) ? int'(-s) : int'(s);
      dev = (mag * m) / 256;
      return (s < 0.0) ? 512 - dev : 512 + dev;
   endfunction

   // reset, then step the position k times and freeze it
   task automatic park(input int k, input int m);
      @(negedge clk);
      rst      = 1'b1;
      step_div = 16'd0;
      mod_idx  = m[7:0];
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (k) @(negedge clk);
      step_div = 16'hFFFF;
   endtask

   task automatic count_high(output int hp, output int hn);
      hp = 0;
      hn = 0;
      for (int i = 0; i < PERIOD; i++) begin
         @(negedge clk);
         if (pwm_p) hp++;
         if (pwm_n) hn++;
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int hp, hn, e, t0, gap;

      // R7: reset state, after some activity first
      repeat (3) @(negedge clk);
      rst = 1'b0;
      repeat (300) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 phase_idx in reset", phase_idx, 0);
      check("R7 duty_lvl in reset", duty_lvl, 0);
      check("R7 pwm_p in reset", pwm_p, 0);
      check("R7 pwm_n in reset", pwm_n, 0);

      // R2: pacing with D=3 from reset release
      step_div = 16'd3;
      mod_idx  = 8'd100;
      @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      check("R2 first step", phase_idx, 1);
      repeat (3) @(negedge clk);
      check("R2 hold before tick", phase_idx, 1);
      repeat (389) @(negedge clk);
      check("R2 last sample", phase_idx, 99);
      repeat (4) @(negedge clk);
      check("R2 wrap to zero", phase_idx, 0);

      // vector table: R3 threshold, R5/R6 duty counts, R8/R9 corners
      for (int v = 0; v < NVEC; v++) begin
         int k, m;
         k = int'(VEC[v][15:8]);
         m = int'(VEC[v][7:0]);
         e = exp_lvl(k, m);
         park(k, m);
         repeat (2100) @(negedge clk);
         check($sformatf("R2 parked position v%0d", v), phase_idx, k);
         if (m == 0)
            check("R8 zero depth level", duty_lvl, 512);
         else if (m == 255 && (k == 25 || k == 75))
            check("R9 extreme level", duty_lvl, (k == 25) ? 1022 : 2);
         else
            check($sformatf("R3 level v%0d", v), duty_lvl, e);
         count_high(hp, hn);
         check($sformatf("R5 pwm_p high count v%0d", v), hp, 2 * e - 1);
         check($sformatf("R6 pwm_n high count v%0d", v), hn, PERIOD - (2 * e - 1));
      end

      // R1: spacing of pwm_p rising edges
      park(0, 0);
      repeat (2100) @(negedge clk);
      @(posedge pwm_p);
      t0 = cyc;
      @(posedge pwm_p);
      gap = cyc - t0;
      check("R1 carrier period", gap, PERIOD);

      // R4: depth change mid-slope waits for the next turning point
      park(10, 128);
      repeat (2100) @(negedge clk);
      e = exp_lvl(10, 128);
      @(negedge pwm_p);
      @(negedge clk);
      mod_idx = 8'd0;
      repeat (20) @(negedge clk);
      check("R4 level held mid-slope", duty_lvl, e);
      repeat (1100) @(negedge clk);
      check("R4 level after turn", duty_lvl, 512);

      // R10: lowering the divider below the running count ticks at once
      park(40, 50);
      repeat (50) @(negedge clk);
      check("R10 parked", phase_idx, 40);
      step_div = 16'd5;
      @(negedge clk);
      check("R10 immediate tick", phase_idx, 41);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule